// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block scans a keypad wired as a matrix of `ROWS` row outputs and `COLS` column inputs. Columns are pulled up and a closed key pulls its column low while its row is driven low. The block uses two phases. In the first phase it drives every row low and watches the columns to see whether any key is closed. Only when a column reads low does it start the second phase. In that phase it drives one row low at a time, from row 0 upward, until a column reads low. The key it finds is the one where the driven row and the low column cross.

Column inputs pass through a synchroniser. Each scan step waits for a clock-enable `tick`. After every change of the row pattern, one tick passes before the columns are sampled, so the lines can settle. A key is reported only after the same row and column have been found on `DEBOUNCE` passes in a row. The report is a one-cycle `key_valid` pulse together with binary row and column indices. After a report, no further report is made until a detect-phase sample sees every column high.

Top module: `kpad_scan`

## Requirements
- R1: A synchronous active-high `rst` returns the block to the detect phase. While reset is held and in the cycle after it, `row_n` is all zeros, `key_valid` is 0, and `key_row` and `key_col` are 0. Reset also clears the debounce count and the release lock, so a key held through reset is reported again.
- R2: In the detect phase every bit of `row_n` is 0. While no column reads low, the block stays in this phase and all rows stay low.
- R3: In the locate phase exactly one bit of `row_n` is 0 and all others are 1. The walk starts with row 0 (`row_n` = 1110 for four rows) and moves up one row at a time. After each change of the row pattern, one tick passes before the columns are sampled. Ticks must be at least 3 clock cycles apart.
- R4: A located key is reported with `key_row` = i, where i is the bit of `row_n` driven low, and `key_col` = j, where j is the bit of `col_n` that reads low.
- R5: A key is reported only after the same row and column are located on `DEBOUNCE` consecutive passes (default 3). A press that lasts for fewer passes is never reported. A pass that finds a different key restarts the count. A walk that finds no low column returns to the detect phase without a report and clears the count.
- R6: A key that is held gives exactly one report. After a report, no new report is made, even for other keys, until a detect-phase sample sees every column high.
- R7: When more than one key is closed, the lowest-numbered row that has a closed key wins. Within that row, the lowest-numbered low column wins.
- R8: `key_valid` is high for exactly one clock cycle per report. `key_row` and `key_col` keep the last reported value until the next report.
- R9: The row pattern changes only in the cycle after `tick` was high. With `tick` held at 0, no scanning happens and no key is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Scan step enable, one clock cycle wide |
| col_n | input | COLS | Column inputs, pulled high, low when a key in a driven row is closed |
| row_n | output | ROWS | Row drives, active low |
| key_valid | output | 1 | One-cycle pulse when a key is reported |
| key_row | output | clog2(ROWS) | Row index of the reported key |
| key_col | output | clog2(COLS), at least 1 | Column index of the reported key |

## Verification
Errors in the internal state show up at the ports in different ways.
- A phase register stuck in locate, or a row index that skips or goes backward, shows on `row_n` within one or two ticks of a press: the first row pattern is no longer 1110, or the pattern after it is no longer 1101.
- A debounce counter that saturates early or never clears shows as a report from a glitch of a few ticks, or as a missing report.
- A release lock that is never set shows as a second `key_valid` pulse within one pass (about ten ticks). A lock that is never cleared shows as a missing report on the next press.
- A wrong index or priority shows as the wrong `key_row` or `key_col` on the first pulse.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

   typedef enum logic {
      PH_DETECT = 1'b0,
      PH_LOCATE = 1'b1
   } kp_phase_e;

   function automatic int kp_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/kpad_colsync.sv
module kpad_colsync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din_n,
   output logic [WIDTH-1:0] dout_n
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("kpad_colsync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '1;
      end else begin
         chain[0] <= din_n;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign dout_n = chain[STAGES-1];

endmodule

// File: rtl/kpad_walk.sv
module kpad_walk
   import kpad_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int RW  = kp_idx_w(ROWS),
   localparam int CW  = kp_idx_w(COLS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [COLS-1:0] col_low,
   output logic [ROWS-1:0] row_n,
   output logic            hit,
   output logic [RW-1:0]   hit_row,
   output logic [CW-1:0]   hit_col,
   output logic            miss,
   output logic            all_up
);

   kp_phase_e      phase;
   logic [RW-1:0]  row_idx;
   logic           settled;
   logic [CW-1:0]  pick;
   logic           any_low;

   assign any_low = |col_low;

   always_comb begin
      pick = '0;
      for (int j = COLS - 1; j >= 0; j--) begin
         if (col_low[j]) pick = CW'(j);
      end
   end

   always_comb begin
      for (int i = 0; i < ROWS; i++) begin
         row_n[i] = (phase == PH_LOCATE) ? (row_idx != RW'(i)) : 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_DETECT;
         row_idx <= '0;
         settled <= 1'b0;
         hit     <= 1'b0;
         miss    <= 1'b0;
         all_up  <= 1'b0;
         hit_row <= '0;
         hit_col <= '0;
      end else begin
         hit    <= 1'b0;
         miss   <= 1'b0;
         all_up <= 1'b0;
         if (tick) begin
            if (!settled) begin
               settled <= 1'b1;
            end else begin
               unique case (phase)
                  PH_DETECT: begin
                     if (any_low) begin
                        phase   <= PH_LOCATE;
                        row_idx <= '0;
                        settled <= 1'b0;
                     end else begin
                        all_up <= 1'b1;
                     end
                  end
                  PH_LOCATE: begin
                     if (any_low) begin
                        hit     <= 1'b1;
                        hit_row <= row_idx;
                        hit_col <= pick;
                        phase   <= PH_DETECT;
                        settled <= 1'b0;
                     end else if (row_idx == RW'(ROWS - 1)) begin
                        miss    <= 1'b1;
                        phase   <= PH_DETECT;
                        settled <= 1'b0;
                     end else begin
                        row_idx <= row_idx + RW'(1);
                        settled <= 1'b0;
                     end
                  end
                  default: phase <= PH_DETECT;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/kpad_confirm.sv
module kpad_confirm
   import kpad_pkg::*;
#(
   parameter int ROWS     = 4,
   parameter int COLS     = 4,
   parameter int DEBOUNCE = 3,
   localparam int RW      = kp_idx_w(ROWS),
   localparam int CW      = kp_idx_w(COLS),
   localparam int CNTW    = $clog2(DEBOUNCE + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hit,
   input  logic [RW-1:0] hit_row,
   input  logic [CW-1:0] hit_col,
   input  logic          miss,
   input  logic          all_up,
   output logic          key_valid,
   output logic [RW-1:0] key_row,
   output logic [CW-1:0] key_col
);

   localparam logic [CNTW-1:0] TARGET = CNTW'(DEBOUNCE);

   logic [RW-1:0]   last_row;
   logic [CW-1:0]   last_col;
   logic [CNTW-1:0] cnt;
   logic [CNTW-1:0] cnt_nx;
   logic            lock;
   logic            same;

   assign same = (cnt != '0) && (last_row == hit_row) && (last_col == hit_col);

   always_comb begin
      if (same) cnt_nx = (cnt < TARGET) ? cnt + CNTW'(1) : cnt;
      else      cnt_nx = CNTW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_row  <= '0;
         last_col  <= '0;
         cnt       <= '0;
         lock      <= 1'b0;
         key_valid <= 1'b0;
         key_row   <= '0;
         key_col   <= '0;
      end else begin
         key_valid <= 1'b0;
         if (hit) begin
            last_row <= hit_row;
            last_col <= hit_col;
            cnt      <= cnt_nx;
            if (cnt_nx == TARGET && !lock) begin
               key_valid <= 1'b1;
               key_row   <= hit_row;
               key_col   <= hit_col;
               lock      <= 1'b1;
            end
         end else if (miss) begin
            cnt <= '0;
         end else if (all_up) begin
            cnt  <= '0;
            lock <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
   import kpad_pkg::*;
#(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int DEBOUNCE    = 3,
   parameter int SYNC_STAGES = 2,
   localparam int RW         = kp_idx_w(ROWS),
   localparam int CW         = kp_idx_w(COLS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [COLS-1:0] col_n,
   output logic [ROWS-1:0] row_n,
   output logic            key_valid,
   output logic [RW-1:0]   key_row,
   output logic [CW-1:0]   key_col
);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("kpad_scan: ROWS must be at least 2");
      end
      if (COLS < 1) begin : g_bad_cols
         $error("kpad_scan: COLS must be at least 1");
      end
      if (DEBOUNCE < 1) begin : g_bad_deb
         $error("kpad_scan: DEBOUNCE must be at least 1");
      end
   endgenerate

   logic [COLS-1:0] col_sync_n;
   logic            hit;
   logic            miss;
   logic            all_up;
   logic [RW-1:0]   hit_row;
   logic [CW-1:0]   hit_col;

   kpad_colsync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst    (rst),
      .din_n  (col_n),
      .dout_n (col_sync_n)
   );

   kpad_walk #(.ROWS(ROWS), .COLS(COLS)) walk_i (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .col_low (~col_sync_n),
      .row_n   (row_n),
      .hit     (hit),
      .hit_row (hit_row),
      .hit_col (hit_col),
      .miss    (miss),
      .all_up  (all_up)
   );

   kpad_confirm #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE(DEBOUNCE)) conf_i (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit),
      .hit_row   (hit_row),
      .hit_col   (hit_col),
      .miss      (miss),
      .all_up    (all_up),
      .key_valid (key_valid),
      .key_row   (key_row),
      .key_col   (key_col)
   );

endmodule

// File: rtl/kpad_scan_chk.sv
module kpad_scan_chk #(
   parameter int ROWS = 4,
   parameter int RW   = 2,
   parameter int CW   = 2
) (
   input logic            clk,
   input logic            rst,
   input logic            tick,
   input logic [ROWS-1:0] row_n,
   input logic            key_valid,
   input logic [RW-1:0]   key_row,
   input logic [CW-1:0]   key_col
);

   // R2 / R3: either all rows low, or exactly one row low
   assert_rows_shape_R3: assert property (@(posedge clk) disable iff (rst)
      (row_n == '0) || ($countones(~row_n) == 1));

   // R1: the cycle after reset sees all rows low and no report
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (row_n == '0) && !key_valid);

   // R8: report pulse lasts one cycle
   assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      key_valid |=> !key_valid);

   // R8: indices hold after a report
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !key_valid && !$past(rst) |-> $stable(key_row) && $stable(key_col));

   // R9: row pattern moves only after a tick
   assert_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$stable(row_n) |-> $past(tick));

endmodule

bind kpad_scan kpad_scan_chk #(.ROWS(ROWS), .RW(RW), .CW(CW)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .row_n     (row_n),
   .key_valid (key_valid),
   .key_row   (key_row),
   .key_col   (key_col)
);

// File: tb/kpad_scan_tb.sv
module kpad_scan_tb_top;

   localparam int ROWS = 4;
   localparam int COLS = 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            tick = 1'b0;
   logic            tick_en = 1'b1;
   logic [COLS-1:0] col_n;
   logic [ROWS-1:0] row_n;
   logic            key_valid;
   logic [1:0]      key_row;
   logic [1:0]      key_col;

   // two key slots of the keypad model
   logic            k0_en = 1'b0, k1_en = 1'b0;
   int              k0_r = 0, k0_c = 0, k1_r = 0, k1_c = 0;

   int errors = 0;
   int checks = 0;
   int pulses = 0;
   int doubles = 0;
   int cap_r = 0, cap_c = 0;
   logic prev_kv = 1'b0;
   int tcnt = 0;

   // {row, col}
   localparam logic [7:0] VEC [0:5] = '{8'h00, 8'h33, 8'h03, 8'h30, 8'h12, 8'h21};

   always #2.5 clk = ~clk;

   kpad_scan #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE(3), .SYNC_STAGES(2)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .col_n     (col_n),
      .row_n     (row_n),
      .key_valid (key_valid),
      .key_row   (key_row),
      .key_col   (key_col)
   );

   always_comb begin
      for (int c = 0; c < COLS; c++) begin
         col_n[c] = !((k0_en && k0_c == c && !row_n[k0_r]) ||
                      (k1_en && k1_c == c && !row_n[k1_r]));
      end
   end

   // one tick every 4 clock cycles
   always @(posedge clk) begin
      tcnt <= (tcnt + 1) % 4;
      tick <= tick_en && (tcnt == 3);
   end

   always @(negedge clk) begin
      if (!rst && key_valid) begin
         pulses++;
         cap_r = key_row;
         cap_c = key_col;
         if (prev_kv) doubles++;
      end
      prev_kv = !rst && key_valid;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_walk(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk);
         if (row_n != '0) seen = 1'b1;
      end
   endtask

   task automatic release_all();
      k0_en = 1'b0;
      k1_en = 1'b0;
   endtask

   initial begin
      #900000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int p0;
      bit seen;
      logic [ROWS-1:0] rn;

      wait_clk(6);
      // R1: state during reset
      check(row_n == 4'b0000, "R1 rows in reset", row_n, 0);
      check(key_valid == 1'b0 && key_row == 0 && key_col == 0, "R1 outputs in reset",
            {key_valid, key_row, key_col}, 0);
      rst = 1'b0;
      wait_clk(1);
      check(row_n == 4'b0000, "R1 rows after reset", row_n, 0);

      // R2: idle keypad stays in detect with all rows low
      wait_clk(200);
      check(row_n == 4'b0000 && pulses == 0, "R2 idle detect", row_n, 0);

      // R9: no tick, no scanning
      tick_en = 1'b0;
      k0_en = 1'b1; k0_r = 1; k0_c = 1;
      wait_clk(200);
      check(row_n == 4'b0000, "R9 rows without tick", row_n, 0);
      check(pulses == 0, "R9 no report without tick", pulses, 0);
      release_all();
      tick_en = 1'b1;
      wait_clk(200);

      // R3: walk order starts at row 0, then row 1
      k0_en = 1'b1; k0_r = 3; k0_c = 2;
      wait_walk(seen);
      check(seen && row_n == 4'b1110, "R3 first row", row_n, 4'b1110);
      rn = row_n;
      for (int i = 0; i < 100 && row_n == rn; i++) @(negedge clk);
      check(row_n == 4'b1101, "R3 second row", row_n, 4'b1101);
      release_all();
      wait_clk(400);
      p0 = pulses;

      // R4 / R6: table of keys, one report each
      for (int v = 0; v < 6; v++) begin
         p0 = pulses;
         k0_en = 1'b1; k0_r = VEC[v][7:4]; k0_c = VEC[v][3:0];
         wait_clk(600);
         check(pulses - p0 == 1, "R6 one report per hold", pulses - p0, 1);
         check(cap_r == VEC[v][7:4], "R4 row index", cap_r, VEC[v][7:4]);
         check(cap_c == VEC[v][3:0], "R4 col index", cap_c, VEC[v][3:0]);
         release_all();
         wait_clk(300);
      end

      // R8: indices hold, single-cycle pulse
      check(key_row == 2 && key_col == 1, "R8 indices hold", {key_row, key_col}, 4'h9);
      check(doubles == 0, "R8 one-cycle pulse", doubles, 0);

      // R5: short glitch not reported
      p0 = pulses;
      k0_en = 1'b1; k0_r = 0; k0_c = 0;
      wait_clk(20);
      release_all();
      wait_clk(400);
      check(pulses == p0, "R5 glitch ignored", pulses - p0, 0);

      // R6: release lock blocks other keys until all up
      p0 = pulses;
      k0_en = 1'b1; k0_r = 1; k0_c = 0;
      wait_clk(400);
      k1_en = 1'b1; k1_r = 2; k1_c = 3;
      wait_clk(100);
      k0_en = 1'b0;
      wait_clk(600);
      check(pulses - p0 == 1, "R6 blocked while held", pulses - p0, 1);
      release_all();
      wait_clk(300);
      k0_en = 1'b1; k0_r = 2; k0_c = 3;
      wait_clk(600);
      check(pulses - p0 == 2 && cap_r == 2 && cap_c == 3, "R6 report after release",
            cap_r * 16 + cap_c, 8'h23);
      release_all();
      wait_clk(300);

      // R7: priority, same row then different rows
      k0_en = 1'b1; k0_r = 2; k0_c = 3;
      k1_en = 1'b1; k1_r = 2; k1_c = 1;
      wait_clk(600);
      check(cap_r == 2 && cap_c == 1, "R7 lowest column", cap_r * 16 + cap_c, 8'h21);
      release_all();
      wait_clk(300);
      k0_en = 1'b1; k0_r = 3; k0_c = 0;
      k1_en = 1'b1; k1_r = 1; k1_c = 2;
      wait_clk(600);
      check(cap_r == 1 && cap_c == 2, "R7 lowest row", cap_r * 16 + cap_c, 8'h12);
      release_all();
      wait_clk(300);

      // R1: reset in mid-walk, then held key reported again
      k0_en = 1'b1; k0_r = 3; k0_c = 3;
      wait_clk(600);
      wait_walk(seen);
      rst = 1'b1;
      wait_clk(1);
      check(row_n == 4'b0000 && key_valid == 1'b0, "R1 reset mid-walk", row_n, 0);
      wait_clk(2);
      rst = 1'b0;
      p0 = pulses;
      wait_clk(600);
      check(pulses - p0 == 1 && cap_r == 3 && cap_c == 3, "R1 lock cleared by reset",
            pulses - p0, 1);
      release_all();
      wait_clk(100);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule